// File: doc/BRIEF.md
# Register Hazard Scoreboard with Decode Stall

This block keeps a record of which architectural registers still have a write in flight, and holds decode back on read-after-write hazards. Each register has one bit in a busy vector. Decode offers one instruction at a time as two bit masks: the registers it reads and the registers it writes. Completion logic offers a mask of the registers being written back in the current cycle.

Each cycle the block grants a bounded number of source reads. A read is granted only for a register that is not busy, and grants go to the lowest register indices first. The granted sources are removed from the instruction's outstanding set, and any sources that remain are held in the block across stall cycles. While the block holds an instruction, the decode inputs are ignored. When no sources remain outstanding, the instruction passes: its destination registers are reserved in the busy vector. A stall from a later stage freezes decode for the cycle, but write-back retirement still proceeds.

Top module: `hazard_scoreboard`

## Requirements
- R1: After reset, busy is all zero. With dec_valid and down_stall low, stall is 0, and rd_grant and rd_left are zero.
- R2: A source whose bit is set in busy is never granted. It appears in rd_left and stall is 1 until a later cycle in which its busy bit is clear.
- R3: At most RD_PORTS (default 3) sources are granted per cycle, counted across all registers. The granted bits are the lowest-indexed eligible sources (bit i of each mask is register i).
- R4: The granted bits are removed from the outstanding set. While an instruction is held (stall was 1 on the previous edge with an instruction active), its remaining sources and destinations are used, and dec_valid, dec_src and dec_dst are ignored.
- R5: In a cycle where down_stall is low and no sources remain after this cycle's grants, the instruction passes. Its destination bits are set in busy from the next cycle, and stall is 0 in that cycle.
- R6: Every register set in wb_mask is clear in busy in the next cycle, unless a passing instruction reserves the same register in that cycle. In that case the reservation wins and the bit stays set.
- R7: While down_stall is 1, stall is 1, rd_grant is zero, nothing is reserved, and rd_left shows all sources of the active instruction. A newly presented instruction is captured and held with all of its sources outstanding.
- R8: The hazard check uses busy as it stands at the start of the cycle. A register retired through wb_mask in cycle t can first be granted in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode presents a new instruction |
| dec_src | input | NREG | Source register mask of the new instruction |
| dec_dst | input | NREG | Destination register mask of the new instruction |
| wb_mask | input | NREG | Registers written back this cycle |
| down_stall | input | 1 | Stall arriving from a later stage |
| stall | output | 1 | Decode must hold this cycle |
| rd_grant | output | NREG | Source reads granted this cycle |
| rd_left | output | NREG | Sources still outstanding after this cycle's grants |
| busy | output | NREG | Registers with a write in flight |

## Verification
Random streams use sparse source and destination masks with a tenth-rate later-stage stall. They check that grants stay within the port limit, honour the busy vector, and carry over across stalled cycles. One directed case has five free sources, which shows lowest-first selection and the spill into a second cycle; during that second cycle new decode inputs are offered to show that a held instruction ignores them. A reserve-then-read sequence with a write-back in the stalled cycle shows that a retirement becomes visible only one cycle later. Retiring and reserving the same register together shows that the reservation takes priority.

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
  parameter int NREG     = 32,
  parameter int RD_PORTS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [NREG-1:0] dec_src,
  input  logic [NREG-1:0] dec_dst,
  input  logic [NREG-1:0] wb_mask,
  input  logic            down_stall,
  output logic            stall,
  output logic [NREG-1:0] rd_grant,
  output logic [NREG-1:0] rd_left,
  output logic [NREG-1:0] busy
);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [CW-1:0] LIM = CW'(RD_PORTS);

  logic [NREG-1:0] busy_q, left_q, dst_q;
  logic            hold_q;

  logic            act, pass;
  logic [NREG-1:0] act_src, act_dst, elig, remain, reserve;
  logic [CW-1:0]   cnt [NREG+1];

  assign act     = hold_q | dec_valid;
  assign act_src = hold_q ? left_q : (dec_valid ? dec_src : '0);
  assign act_dst = hold_q ? dst_q : dec_dst;
  assign elig    = down_stall ? '0 : (act_src & ~busy_q);

  assign cnt[0] = '0;
  for (genvar i = 0; i < NREG; i++) begin : g_pick
    assign rd_grant[i] = elig[i] && (cnt[i] < LIM);
    assign cnt[i+1]    = cnt[i] + CW'(rd_grant[i]);
  end

  assign remain  = act_src & ~rd_grant;
  assign pass    = act & ~down_stall & ~(|remain);
  assign reserve = pass ? act_dst : '0;
  assign stall   = down_stall | (|remain);
  assign rd_left = remain;
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      left_q <= '0;
      dst_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      busy_q <= (busy_q & ~wb_mask) | reserve;
      hold_q <= act & ~pass;
      left_q <= remain;
      dst_q  <= act_dst;
    end
  end

  assert_port_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_grant) <= RD_PORTS);

  assert_no_busy_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant & busy) == '0);

  assert_down_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    down_stall |-> (stall && rd_grant == '0));

  assert_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((busy & $past(wb_mask & ~reserve)) == '0));

  assert_reserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pass |=> ((busy & $past(act_dst)) == $past(act_dst)));

  assert_left_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!down_stall && rd_left != '0) |-> stall);
endmodule

// File: tb/tb_hazard_scoreboard.sv
module tb_hazard_scoreboard;
  localparam int N = 32;
  localparam int P = 3;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         dec_valid = 0, down_stall = 0;
  logic [N-1:0] dec_src = '0, dec_dst = '0, wb_mask = '0;
  logic         stall;
  logic [N-1:0] rd_grant, rd_left, busy;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [N-1:0] m_busy = '0, m_left = '0, m_dst = '0;
  bit           m_hold = 0;

  always #2.5 clk = ~clk;

  hazard_scoreboard #(.NREG(N), .RD_PORTS(P)) dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
    .dec_dst(dec_dst), .wb_mask(wb_mask), .down_stall(down_stall),
    .stall(stall), .rd_grant(rd_grant), .rd_left(rd_left), .busy(busy));

  function automatic logic [N-1:0] pick_low(input logic [N-1:0] m, input int lim);
    logic [N-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < N; i++)
      if (m[i] && k < lim) begin r[i] = 1'b1; k++; end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare 1 ns later, advance model
  task automatic step(input string tag, input bit v, input logic [N-1:0] s,
                      input logic [N-1:0] d, input logic [N-1:0] wb, input bit ds);
    logic [N-1:0] asrc, adst, g, rem;
    bit act;
    @(negedge clk);
    dec_valid = v; dec_src = s; dec_dst = d; wb_mask = wb; down_stall = ds;
    #1;
    act  = m_hold || v;
    asrc = m_hold ? m_left : (v ? s : '0);
    adst = m_hold ? m_dst : d;
    g    = ds ? '0 : pick_low(asrc & ~m_busy, P);
    rem  = asrc & ~g;
    chk({tag, " busy"}, busy, m_busy);
    chk({tag, " grant"}, rd_grant, g);
    chk({tag, " left"}, rd_left, rem);
    chk({tag, " stall"}, {{(N-1){1'b0}}, stall}, {{(N-1){1'b0}}, (ds || rem != '0)});
    m_busy = m_busy & ~wb;
    if (act && !ds && rem == '0) begin
      m_busy = m_busy | adst;
      m_hold = 0;
    end else begin
      m_hold = act;
    end
    m_left = rem;
    m_dst  = adst;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] s, d, w;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step("R1 reset idle", 0, '0, '0, '0, 0);

    // R3: five free sources, lowest three first; R4: new inputs ignored while held
    step("R3 lowest-first", 1, 32'h8010_0224, 32'h0000_0002, '0, 0);
    chk("R3 grant bits 2,5,9", rd_grant, 32'h0000_0224);
    step("R4 held ignores decode", 1, 32'h0000_00FF, 32'h0000_FF00, '0, 0);
    chk("R4 grant 20,31", rd_grant, 32'h8010_0000);
    step("R5 reserve seen", 0, '0, '0, '0, 0);
    chk("R5 busy bit1", busy, 32'h0000_0002);

    // R2 / R8: read of busy reg stalls; write-back visible next cycle only
    step("R2 reserve r7", 1, '0, 32'h0000_0080, '0, 0);
    step("R2 hazard", 1, 32'h0000_0081, '0, '0, 0);
    chk("R2 only r0 granted", rd_grant, 32'h0000_0001);
    step("R8 retire same cycle", 0, '0, '0, 32'h0000_0082, 0);
    chk("R8 still stalled", {31'b0, stall}, 32'h1);
    step("R8 granted next", 0, '0, '0, '0, 0);
    chk("R8 grant r7", rd_grant, 32'h0000_0080);

    // R6: reserve wins over same-cycle retire
    step("R6 reserve r4", 1, '0, 32'h0000_0010, '0, 0);
    step("R6 retire+reserve", 1, '0, 32'h0000_0010, 32'h0000_0010, 0);
    step("R6 check", 0, '0, '0, '0, 0);
    chk("R6 r4 kept", busy & 32'h10, 32'h10);
    step("R6 clear r4", 0, '0, '0, 32'h0000_0010, 0);
    step("R6 check clear", 0, '0, '0, '0, 0);
    chk("R6 busy zero", busy, '0);

    // R7: later-stage stall captures instruction, grants nothing
    step("R7 freeze", 1, 32'h0000_0C00, 32'h0000_1000, '0, 1);
    chk("R7 left all", rd_left, 32'h0000_0C00);
    step("R7 freeze again", 1, 32'h1, '0, '0, 1);
    step("R7 release", 0, '0, '0, '0, 0);
    chk("R7 grant 10,11", rd_grant, 32'h0000_0C00);

    for (int i = 0; i < 3000; i++) begin
      s = '0; d = '0; w = '0;
      for (int b = 0; b < N; b++) begin
        if ($urandom_range(0, 7) == 0) s[b] = 1'b1;
        if ($urandom_range(0, 19) == 0) d[b] = 1'b1;
        if (m_busy[b] && $urandom_range(0, 3) == 0) w[b] = 1'b1;
      end
      step(m_hold ? "R4 rand" : "R3 rand", $urandom_range(0, 3) != 0, s, d, w,
           $urandom_range(0, 9) == 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule